// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block takes single-byte data-space read and write requests from a CPU and runs them as cycles on an external parallel memory bus. The low address byte and the data byte share one 8-bit bus. An address-latch strobe marks the cycle in which that shared bus carries the low address, so external logic can latch it. The high address byte has a dedicated output, and it keeps its last value between accesses. Read and write strobes then frame the data phase.

The external address space is split into a lower and an upper sector. A 3-bit limit field sets the boundary between them, and each sector has its own 2-bit wait-state code. Codes 0, 1 and 2 stretch the strobe by that many cycles. Code 3 stretches the strobe by two cycles and also adds a trailing cycle. In that trailing cycle the latch strobe pulses only when the next CPU access targets RAM.

A global enable bit switches all bus pins between memory-bus use and normal port use. An optional bus keeper holds the last value seen on the shared bus whenever the controller is not driving it. Two 8-bit configuration registers, cleared at reset, hold these settings.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset both configuration registers read zero, `en_o` is low, and `ale_o`, `rd_o`, `wr_o`, `ad_oe_o`, `ad_keep_o` and `done_o` are low.
- R2: Register select 0 is the control register: bit 0 is the interface enable and bit 1 is the keeper enable. Register select 1 is the sector register: bits [2:0] hold the limit, [4:3] the lower-sector wait code and [6:5] the upper-sector wait code. All other bits read zero.
- R3: While the enable bit is clear, `en_o` is low, requests are ignored (no strobe, no latch pulse, no `done_o`), and all bus outputs are held at zero.
- R4: An accepted access starts with one address cycle. In that cycle `ale_o` is 1, `ad_oe_o` is 1, `ad_o` equals address[7:0] and `ahi_o` equals address[15:8]. No strobe is active in that cycle.
- R5: After the address cycle the strobe is active for 1+min(code,2) consecutive cycles. The strobe is `rd_o` for a read and `wr_o` for a write. One hold cycle with no strobe follows.
- R6: A limit of 0 selects the lower-sector code for every address. Otherwise address[15:13] >= limit selects the upper-sector code, and any lower address selects the lower-sector code.
- R7: Only wait code 3 adds a trailing cycle after the hold cycle. In that trailing cycle `ale_o` equals `next_ram_i`. `ale_o` is never high at any other point after the address cycle.
- R8: `done_o` is high for exactly the final cycle of the access. Including the address cycle, an access lasts 3+min(code,2) cycles, plus 1 for code 3. From that cycle onward, `rdata_o` of a read holds `ad_i` as sampled in the last strobe cycle.
- R9: During a write, `ad_oe_o` is 1 and `ad_o` carries the write data in every strobe cycle.
- R10: With the keeper enabled and the bus not driven, `ad_keep_o` is 1 and `ad_o` shows the last value on the bus, including read data. With the keeper disabled, `ad_keep_o` is 0 and an undriven `ad_o` is 0.
- R11: `ahi_o` keeps the high byte of the previous address while the interface is idle.
- R12: A request raised while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 control, 1 sector |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read-back of the selected register |
| req_i | input | 1 | Access request, sampled while idle |
| req_we_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| next_ram_i | input | 1 | Next CPU access targets RAM |
| done_o | output | 1 | High in the final cycle of an access |
| rdata_o | output | 8 | Captured read data |
| en_o | output | 1 | Bus pins act as memory bus |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| ad_o | output | 8 | Shared address/data bus out value |
| ad_oe_o | output | 1 | Controller drives the shared bus |
| ad_keep_o | output | 1 | Keeper holds the shared bus |
| ad_i | input | 8 | Shared bus input value |
| ahi_o | output | 8 | High address byte |

## Verification
Some rules are checked by assertions on every cycle. These cover: the read and write strobes are never active together, and neither is active alongside the latch strobe; the high address changes only when an access starts; `done_o` never lasts two cycles; the trailing state is reached only under code 3; an undriven kept bus stays stable; reserved bits read as zero. Other behaviour can only be shown by the bench's scenarios. This covers the cycle counts per wait code, the sector choice around the limit, the latch pulse in the trailing cycle, the captured read data and the keeper value after a read. For these the bench predicts each access and compares it with what appears on the bus.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LIM_W = 3;
  localparam int WC_W  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_STRB, S_HOLD, S_TAIL
  } seq_state_e;

  typedef struct packed {
    logic             en;
    logic             keep;
    logic [LIM_W-1:0] limit;
    logic [WC_W-1:0]  wc_lo;
    logic [WC_W-1:0]  wc_hi;
  } xcfg_t;
endpackage

// File: rtl/xbus_regs.sv
module xbus_regs
  import xbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output xcfg_t         cfg_o
);
  localparam int SEC_USED = LIM_W + 2 * WC_W;

  xcfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      if (!sel_i) begin
        cfg_q.en   <= wdata_i[0];
        cfg_q.keep <= wdata_i[1];
      end else begin
        cfg_q.limit <= wdata_i[LIM_W-1:0];
        cfg_q.wc_lo <= wdata_i[LIM_W +: WC_W];
        cfg_q.wc_hi <= wdata_i[LIM_W+WC_W +: WC_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[0] = cfg_q.en;
      rdata_o[1] = cfg_q.keep;
    end else begin
      rdata_o[SEC_USED-1:0] = {cfg_q.wc_hi, cfg_q.wc_lo, cfg_q.limit};
    end
  end

  assign cfg_o = cfg_q;

  // R2: top bit is reserved in both registers
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1] == 1'b0);
endmodule

// File: rtl/xbus_sector.sv
module xbus_sector
  import xbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]   addr_i,
  input  xcfg_t           cfg_i,
  output logic [WC_W-1:0] wcode_o
);
  logic [LIM_W-1:0] top;
  logic             upper;

  assign top     = addr_i[AW-1 -: LIM_W];
  assign upper   = (cfg_i.limit != '0) && (top >= cfg_i.limit);
  assign wcode_o = upper ? cfg_i.wc_hi : cfg_i.wc_lo;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [WC_W-1:0] wcode_i,
  input  logic            next_ram_i,
  input  logic [DW-1:0]   ad_i,
  output logic            ale_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            drv_oe_o,
  output logic [DW-1:0]   drv_val_o,
  output logic [AW-DW-1:0] ahi_o,
  output logic            done_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int HW = AW - DW;
  localparam logic [WC_W-1:0] WC_MAX = '1;
  localparam logic [WC_W-1:0] STR_MAX = WC_MAX - 1'b1;

  seq_state_e      state_q;
  logic [WC_W-1:0] cnt_q;
  logic [WC_W-1:0] code_q;
  logic            we_q;
  logic [DW-1:0]   alo_q;
  logic [HW-1:0]   ahi_q;
  logic [DW-1:0]   wd_q;
  logic [DW-1:0]   rd_q;
  logic            tail_en;

  assign tail_en = (code_q == WC_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      code_q  <= '0;
      we_q    <= 1'b0;
      alo_q   <= '0;
      ahi_q   <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (en_i && req_i) begin
          state_q <= S_ADDR;
          code_q  <= wcode_i;
          we_q    <= we_i;
          alo_q   <= addr_i[DW-1:0];
          ahi_q   <= addr_i[AW-1:DW];
          wd_q    <= wdata_i;
        end
        S_ADDR: begin
          state_q <= S_STRB;
          cnt_q   <= (code_q > STR_MAX) ? STR_MAX : code_q;
        end
        S_STRB: begin
          if (cnt_q == '0) begin
            state_q <= S_HOLD;
            if (!we_q) rd_q <= ad_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_HOLD:  state_q <= tail_en ? S_TAIL : S_IDLE;
        S_TAIL:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ale_o     = (state_q == S_ADDR) || ((state_q == S_TAIL) && next_ram_i);
  assign rd_o      = (state_q == S_STRB) && !we_q;
  assign wr_o      = (state_q == S_STRB) && we_q;
  assign drv_oe_o  = (state_q == S_ADDR) ||
                     (we_q && ((state_q == S_STRB) || (state_q == S_HOLD)));
  assign drv_val_o = (state_q == S_ADDR) ? alo_q : wd_q;
  assign ahi_o     = ahi_q;
  assign done_o    = ((state_q == S_HOLD) && !tail_en) || (state_q == S_TAIL);
  assign rdata_o   = rd_q;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_ale_no_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !(rd_o || wr_o));
  p_ahi_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ahi_q) |-> (state_q == S_ADDR));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_tail_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAIL) |-> (code_q == WC_MAX));
  p_strb_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STRB) |=> (state_q == S_STRB || state_q == S_HOLD));
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          keep_i,
  input  logic          drv_oe_i,
  input  logic [DW-1:0] drv_val_i,
  input  logic          rd_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_keep_o
);
  logic [DW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (drv_oe_i) last_q <= drv_val_i;
    else if (rd_i)     last_q <= ad_i;
  end

  always_comb begin
    ad_o = '0;
    if (en_i) begin
      if (drv_oe_i)    ad_o = drv_val_i;
      else if (keep_i) ad_o = last_q;
    end
  end

  assign ad_keep_o = en_i && keep_i && !drv_oe_i;

  p_keep_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_keep_o && $past(ad_keep_o) && !$past(rd_i)) |-> $stable(ad_o));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  output logic [DW-1:0]      cfg_rdata_o,
  input  logic               req_i,
  input  logic               req_we_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic               next_ram_i,
  output logic               done_o,
  output logic [DW-1:0]      rdata_o,
  output logic               en_o,
  output logic               ale_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe_o,
  output logic               ad_keep_o,
  input  logic [DW-1:0]      ad_i,
  output logic [AW-DW-1:0]   ahi_o
);
  localparam int HW = AW - DW;

  xcfg_t           cfg;
  logic [WC_W-1:0] wcode;
  logic            s_ale, s_rd, s_wr, s_oe, s_done;
  logic [DW-1:0]   s_val;
  logic [HW-1:0]   s_ahi;

  xbus_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  xbus_sector #(.AW(AW)) u_sector (
    .addr_i  (req_addr_i),
    .cfg_i   (cfg),
    .wcode_o (wcode)
  );

  xbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg.en),
    .req_i      (req_i),
    .we_i       (req_we_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .wcode_i    (wcode),
    .next_ram_i (next_ram_i),
    .ad_i       (ad_i),
    .ale_o      (s_ale),
    .rd_o       (s_rd),
    .wr_o       (s_wr),
    .drv_oe_o   (s_oe),
    .drv_val_o  (s_val),
    .ahi_o      (s_ahi),
    .done_o     (s_done),
    .rdata_o    (rdata_o)
  );

  xbus_keeper #(.DW(DW)) u_keeper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg.en),
    .keep_i    (cfg.keep),
    .drv_oe_i  (s_oe),
    .drv_val_i (s_val),
    .rd_i      (s_rd),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_keep_o (ad_keep_o)
  );

  assign en_o    = cfg.en;
  assign ale_o   = cfg.en && s_ale;
  assign rd_o    = cfg.en && s_rd;
  assign wr_o    = cfg.en && s_wr;
  assign ad_oe_o = cfg.en && s_oe;
  assign done_o  = s_done;
  assign ahi_o   = cfg.en ? s_ahi : '0;

  p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !(ale_o || rd_o || wr_o || ad_oe_o || ad_keep_o));
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic        req = 1'b0, req_we = 1'b0, next_ram = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rdata, ad, ad_in = '0, ahi;
  logic        done, en, ale, rd, wr, ad_oe, ad_keep;

  xbus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .next_ram_i(next_ram), .done_o(done), .rdata_o(rdata),
    .en_o(en), .ale_o(ale), .rd_o(rd), .wr_o(wr), .ad_o(ad), .ad_oe_o(ad_oe),
    .ad_keep_o(ad_keep), .ad_i(ad_in), .ahi_o(ahi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rv;
    int          ncyc;
    int          nstrb;
    bit          tail;
    bit          nram;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, act_cnt = 0;
  logic [2:0] lim = 0;
  logic [1:0] wlo = 0, whi = 0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [15:0] a);
    if (lim != 0 && a[15:13] >= lim) return int'(whi);
    return int'(wlo);
  endfunction

  // monitor
  bit busy = 0;
  int ncyc = 0, nstrb = 0, nrd = 0, nwr = 0;
  item_t cur;
  always @(negedge clk) begin
    if (ale || rd || wr || done) act_cnt++;
    if (rst_n && !busy && ale) begin
      if (q.size() == 0) begin
        chk(0, "R12", "unexpected access start", 1, 0);
      end else begin
        cur = q[0];
        busy = 1; ncyc = 1; nstrb = 0; nrd = 0; nwr = 0;
        chk(ad === cur.addr[7:0] && ad_oe, "R4", "address phase low byte", int'(ad), int'(cur.addr[7:0]));
        chk(ahi === cur.addr[15:8], "R4", "address phase high byte", int'(ahi), int'(cur.addr[15:8]));
      end
    end else if (busy) begin
      ncyc++;
      if (rd) nrd++;
      if (wr) begin
        nwr++;
        chk(ad_oe && ad === cur.wd, "R9", "write data on strobe", int'(ad), int'(cur.wd));
      end
      if (rd || wr) nstrb++;
      if (ale && !(done && cur.tail))
        chk(0, "R7", "stray latch pulse", 1, 0);
      if (done) begin
        void'(q.pop_front());
        busy = 0;
        chk(ncyc == cur.ncyc, "R8", "access length", ncyc, cur.ncyc);
        chk(nstrb == cur.nstrb, "R5", "strobe cycles", nstrb, cur.nstrb);
        chk(cur.we ? (nrd == 0) : (nwr == 0), "R5", "strobe kind", cur.we ? nrd : nwr, 0);
        if (cur.tail) chk(ale == cur.nram, "R7", "trailing latch pulse", int'(ale), int'(cur.nram));
        if (!cur.we) chk(rdata === cur.rv, "R8", "read data", int'(rdata), int'(cur.rv));
      end
    end
  end

  task automatic cfg_wr(input bit sel, input logic [7:0] v);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 0;
    if (sel) begin lim = v[2:0]; wlo = v[4:3]; whi = v[6:5]; end
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] rv, input bit nram);
    item_t it;
    int c = exp_code(a);
    int n = (c > 2) ? 2 : c;
    it.we = we; it.addr = a; it.wd = wd; it.rv = rv;
    it.nstrb = 1 + n; it.tail = (c == 3); it.nram = nram;
    it.ncyc = 3 + n + (c == 3 ? 1 : 0);
    q.push_back(it);
    @(negedge clk); #1;
    req = 1; req_we = we; req_addr = a; req_wdata = wd; ad_in = rv; next_ram = nram;
    @(negedge clk); #1;
    req = 0;
    for (int i = 0; i < 40 && q.size() != 0; i++) begin
      @(negedge clk); #1;
    end
    chk(q.size() == 0, "R8", "access completes", q.size(), 0);
    q.delete();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cfg_sel = 0; #1;
    chk(cfg_rdata == 8'h00, "R1", "ctrl reset", int'(cfg_rdata), 0);
    cfg_sel = 1; #1;
    chk(cfg_rdata == 8'h00, "R1", "sector reset", int'(cfg_rdata), 0);
    chk({en, ale, rd, wr, ad_oe, ad_keep, done} == 7'b0, "R1", "outputs idle",
        int'({en, ale, rd, wr, ad_oe, ad_keep, done}), 0);
    rst_n = 1;

    // R3 disabled: request ignored
    act_cnt = 0;
    @(negedge clk); #1; req = 1; req_addr = 16'h1234;
    @(negedge clk); #1; req = 0;
    repeat (8) @(negedge clk);
    #1;
    chk(act_cnt == 0 && !en && ad == 0 && ahi == 0, "R3", "no activity while off", act_cnt, 0);

    // R2 register layout
    cfg_wr(0, 8'hFF);
    cfg_sel = 0; #1;
    chk(cfg_rdata == 8'h03, "R2", "ctrl readback", int'(cfg_rdata), 3);
    cfg_wr(1, 8'hFF);
    cfg_sel = 1; #1;
    chk(cfg_rdata == 8'h7F, "R2", "sector readback", int'(cfg_rdata), 8'h7F);

    // R6 limit 0: lower code 0 everywhere, upper code 3 unused
    cfg_wr(1, 8'h60);
    access(0, 16'hF000, 8'h00, 8'hA5, 1);
    access(1, 16'hE0F1, 8'h3C, 8'h00, 1);

    // R6 limit 4, lower 1, upper 2
    cfg_wr(1, 8'h4C);
    access(0, 16'h2345, 8'h00, 8'h5E, 0);
    access(1, 16'h9ABC, 8'h77, 8'h00, 0);
    access(0, 16'h8000, 8'h00, 8'hC3, 0);
    access(0, 16'h7FFF, 8'h00, 8'h19, 0);

    // R7 code 3 with trailing cycle; limit 2, lower 2, upper 3
    cfg_wr(1, 8'h72);
    access(1, 16'h4001, 8'hE2, 8'h00, 1);
    access(0, 16'h5A5A, 8'h00, 8'h6B, 0);
    access(0, 16'h1234, 8'h00, 8'hD4, 1);

    // R10 keeper on after a read
    @(negedge clk); #1;
    chk(ad_keep && !ad_oe && ad == 8'hD4, "R10", "keeper holds read data", int'(ad), 8'hD4);
    // R11 high byte held while idle
    repeat (3) @(negedge clk);
    #1;
    chk(ahi == 8'h12, "R11", "high address held", int'(ahi), 8'h12);
    cfg_wr(0, 8'h01);
    #1;
    chk(!ad_keep && ad == 8'h00, "R10", "keeper off releases bus", int'(ad), 0);

    // R12 request during busy access ignored
    q.push_back('{we: 0, addr: 16'h6000, wd: 8'h00, rv: 8'h81, ncyc: 6, nstrb: 3, tail: 1, nram: 0});
    @(negedge clk); #1;
    req = 1; req_we = 0; req_addr = 16'h6000; ad_in = 8'h81; next_ram = 0;
    @(negedge clk); #1; req = 0;
    @(negedge clk); #1; req = 1; req_addr = 16'h0100;
    @(negedge clk); #1; req = 0;
    repeat (10) @(negedge clk);
    #1;
    chk(q.size() == 0 && !busy, "R12", "single access only", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule